// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block is the address-phase front end of an I2C target. It watches already-synchronized SCL and SDA inputs and finds START and STOP conditions. After each START it shifts in the address byte, or the two address bytes, and decides whether this target is the one being addressed. When a byte matches, it requests the acknowledge by asserting a pull-low enable on SDA for the ninth clock. It never drives SDA high.

Software sets up the block through two byte-wide registers. The control register holds the general-call enable, the address-length select and the upper address bits used in ten-bit mode. The address register holds the own address: the low seven bits in seven-bit mode, or the low byte in ten-bit mode. The block reports the result on four registered outputs: a match flag, a general-call flag, the transfer direction and the SDA pull request. The transfer of data bytes after the address phase is handled elsewhere.

Top module: `i2c_addr_match`

## Requirements
- R1: With `reg_sel`=0 the control register is selected: bit 7 is the general-call enable, bit 6 is the address type (0 = seven-bit, 1 = ten-bit), and bits 2:0 hold the upper address field. Bits 5:3 always read 0. With `reg_sel`=1 the 8-bit own-address register is selected. Both registers reset to 0. `reg_rdata` shows the selected register one clock after `reg_sel` is applied.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Each one clears the partly shifted byte and the `addr_hit`, `gcall_hit` and `dir_tx` flags, and releases `sda_pull` one clock later. A repeated START behaves the same way.
- R3: In seven-bit mode, bits are sampled on SCL rising edges, MSB first. If bits 7:1 of the first byte equal own-address bits 6:0 (own address not zero), `addr_hit` rises one clock after the eighth rising edge and `dir_tx` takes bit 0 of the byte.
- R4: For a byte that matches, `sda_pull` asserts one clock after the SCL falling edge that ends the eighth bit. It releases one clock after the SCL falling edge that ends the ninth clock.
- R5: If a byte does not match, there is no acknowledge and no flag. All later bits are ignored until the next START.
- R6: A first byte of 0x00 is a general call. It is acknowledged with `gcall_hit`=1, `addr_hit`=0 and `dir_tx`=0 only when the enable bit is 1. When the enable bit is 0 it is not acknowledged and sets no flag. A first byte of 0x01 is never acknowledged.
- R7: The address type is latched at START. A write to it in the middle of a transaction does not change how that transaction is decoded.
- R8: In ten-bit mode, the first byte 11110 followed by control bits 1:0 and R/W=0 is acknowledged without `addr_hit`. The second byte must equal the own-address register; it is then acknowledged with `addr_hit`=1 and `dir_tx`=0. Control bit 2 does not take part in the compare.
- R9: In ten-bit mode, a second byte that does not match gets no acknowledge and no `addr_hit`.
- R10: A repeated START that follows a complete ten-bit match, with no STOP in between, and carries the prefix byte with R/W=1 is acknowledged with `addr_hit`=1 and `dir_tx`=1. The same byte is not acknowledged without such a preceding match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl | input | 1 | Synchronized SCL level |
| sda | input | 1 | Synchronized SDA level (wired-AND bus value) |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 own address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data of the selected register |
| addr_hit | output | 1 | Own address fully matched |
| gcall_hit | output | 1 | General call accepted |
| dir_tx | output | 1 | 1 when the master reads from this target |
| sda_pull | output | 1 | Pull-low enable for SDA |

## Verification
The bench changes inputs just after a rising clock edge, so the design sees each change at the next edge. The match, general-call and direction flags are due one clock after the edge that samples the eighth SCL rise. The pull request follows one clock after the matching SCL fall, and it releases one clock after the ninth fall. Flags clear one clock after a START or STOP. Register readback is due one clock after the select is applied. The bench updates its expected values right after the edge where each result is due and compares all four status outputs at every falling clock edge.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_HOLD,
    ST_ACK,
    ST_DONE
  } am_state_t;

  typedef struct packed {
    logic       gc_en;
    logic       ten_bit;
    logic [2:0] hi_addr;
  } am_cfg_t;

  localparam int          PFX_W      = 5;
  localparam logic [4:0]  TEN_PREFIX = 5'b11110;
  localparam int          HI_PAIR_W  = 2;

endpackage

// File: rtl/i2c_am_bus_evt.sv
module i2c_am_bus_evt (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic scl_q;
  logic sda_q;

  // Previous levels; idle bus is high, so reset to 1 avoids false events.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_evt = scl & scl_q & sda_q & ~sda;
  assign stop_evt  = scl & scl_q & ~sda_q & sda;

endmodule

// File: rtl/i2c_am_regs.sv
module i2c_am_regs
  import i2c_am_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic                 sel,
  input  logic [BYTE_W-1:0]    wdata,
  output logic                 gc_en,
  output logic                 ten_bit,
  output logic [HI_PAIR_W-1:0] hi_pair,
  output logic [BYTE_W-1:0]    own_addr,
  output logic [BYTE_W-1:0]    rdata
);

  localparam int GC_POS   = BYTE_W - 1;
  localparam int TYPE_POS = BYTE_W - 2;
  localparam int HI_W     = 3;

  am_cfg_t          cfg;
  logic [BYTE_W-1:0] ctrl_view;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      own_addr <= '0;
      rdata    <= '0;
    end else begin
      if (we && !sel) begin
        cfg.gc_en   <= wdata[GC_POS];
        cfg.ten_bit <= wdata[TYPE_POS];
        cfg.hi_addr <= wdata[HI_W-1:0];
      end
      if (we && sel) begin
        own_addr <= wdata;
      end
      rdata <= sel ? own_addr : ctrl_view;
    end
  end

  // Readback image: defined fields in place, every other position reads 0.
  generate
    for (genvar b = 0; b < BYTE_W; b++) begin : g_view
      if (b == GC_POS) begin : g_gc
        assign ctrl_view[b] = cfg.gc_en;
      end else if (b == TYPE_POS) begin : g_type
        assign ctrl_view[b] = cfg.ten_bit;
      end else if (b < HI_W) begin : g_hi
        assign ctrl_view[b] = cfg.hi_addr[b];
      end else begin : g_zero
        assign ctrl_view[b] = 1'b0;
      end
    end
  endgenerate

  assign gc_en   = cfg.gc_en;
  assign ten_bit = cfg.ten_bit;
  assign hi_pair = cfg.hi_addr[HI_PAIR_W-1:0];

endmodule

// File: rtl/i2c_am_match.sv
module i2c_am_match
  import i2c_am_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0]    byte_v,
  input  logic                 first,
  input  logic                 ten_mode,
  input  logic                 armed,
  input  logic                 gc_en,
  input  logic [HI_PAIR_W-1:0] hi_pair,
  input  logic [BYTE_W-1:0]    own_addr,
  output logic                 ack_ok,
  output logic                 full_hit,
  output logic                 gc_hit,
  output logic                 dir_rd,
  output logic                 partial
);

  localparam int PFX_LSB = BYTE_W - PFX_W;

  logic [BYTE_W-2:0] own7;
  logic              prefix_ok;

  assign own7      = own_addr[BYTE_W-2:0];
  assign prefix_ok = (byte_v[BYTE_W-1:PFX_LSB] == TEN_PREFIX) &&
                     (byte_v[HI_PAIR_W:1] == hi_pair);

  always_comb begin
    ack_ok   = 1'b0;
    full_hit = 1'b0;
    gc_hit   = 1'b0;
    dir_rd   = 1'b0;
    if (first) begin
      if (byte_v == '0) begin
        if (gc_en) begin
          ack_ok = 1'b1;
          gc_hit = 1'b1;
        end
      end else if (!ten_mode) begin
        if ((byte_v[BYTE_W-1:1] == own7) && (own7 != '0)) begin
          ack_ok   = 1'b1;
          full_hit = 1'b1;
          dir_rd   = byte_v[0];
        end
      end else if (prefix_ok) begin
        if (!byte_v[0]) begin
          ack_ok = 1'b1;
        end else if (armed) begin
          ack_ok   = 1'b1;
          full_hit = 1'b1;
          dir_rd   = 1'b1;
        end
      end
    end else if (byte_v == own_addr) begin
      ack_ok   = 1'b1;
      full_hit = 1'b1;
    end
  end

  assign partial = ack_ok && !full_hit && !gc_hit;

endmodule

// File: rtl/i2c_am_fsm.sv
module i2c_am_fsm
  import i2c_am_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sda,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_evt,
  input  logic                 stop_evt,
  input  logic                 gc_en,
  input  logic                 ten_bit,
  input  logic [HI_PAIR_W-1:0] hi_pair,
  input  logic [BYTE_W-1:0]    own_addr,
  output logic                 addr_hit,
  output logic                 gcall_hit,
  output logic                 dir_tx,
  output logic                 sda_pull
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  am_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-2:0] shreg;
  logic              second;
  logic              ten_q;
  logic              armed;
  logic              ack_pend;
  logic              go_second;
  logic [BYTE_W-1:0] byte_v;

  logic m_ack, m_full, m_gc, m_dir, m_partial;

  assign byte_v = {shreg, sda};

  i2c_am_match #(.BYTE_W(BYTE_W)) u_match (
    .byte_v   (byte_v),
    .first    (!second),
    .ten_mode (ten_q),
    .armed    (armed),
    .gc_en    (gc_en),
    .hi_pair  (hi_pair),
    .own_addr (own_addr),
    .ack_ok   (m_ack),
    .full_hit (m_full),
    .gc_hit   (m_gc),
    .dir_rd   (m_dir),
    .partial  (m_partial)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      second    <= 1'b0;
      ten_q     <= 1'b0;
      armed     <= 1'b0;
      ack_pend  <= 1'b0;
      go_second <= 1'b0;
      addr_hit  <= 1'b0;
      gcall_hit <= 1'b0;
      dir_tx    <= 1'b0;
      sda_pull  <= 1'b0;
    end else if (stop_evt) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      second    <= 1'b0;
      armed     <= 1'b0;
      addr_hit  <= 1'b0;
      gcall_hit <= 1'b0;
      dir_tx    <= 1'b0;
      sda_pull  <= 1'b0;
    end else if (start_evt) begin
      // Repeated START keeps 'armed' so a ten-bit read can follow a write match.
      state     <= ST_SHIFT;
      cnt       <= '0;
      shreg     <= '0;
      second    <= 1'b0;
      ten_q     <= ten_bit;
      addr_hit  <= 1'b0;
      gcall_hit <= 1'b0;
      dir_tx    <= 1'b0;
      sda_pull  <= 1'b0;
    end else begin
      case (state)
        ST_SHIFT: begin
          if (scl_rise) begin
            shreg <= byte_v[BYTE_W-2:0];
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              state     <= ST_HOLD;
              ack_pend  <= m_ack;
              go_second <= m_partial;
              armed     <= ten_q && m_full;
              if (m_full) begin
                addr_hit <= 1'b1;
                dir_tx   <= m_dir;
              end
              if (m_gc) begin
                gcall_hit <= 1'b1;
              end
            end
          end
        end
        ST_HOLD: begin
          if (scl_fall) begin
            if (ack_pend) begin
              sda_pull <= 1'b1;
              state    <= ST_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            cnt      <= '0;
            if (go_second) begin
              second <= 1'b1;
              state  <= ST_SHIFT;
            end else begin
              state <= ST_DONE;
            end
          end
        end
        default: state <= state;
      endcase
    end
  end

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl,
  input  logic              sda,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              addr_hit,
  output logic              gcall_hit,
  output logic              dir_tx,
  output logic              sda_pull
);

  logic                 scl_rise;
  logic                 scl_fall;
  logic                 start_evt;
  logic                 stop_evt;
  logic                 gc_en;
  logic                 ten_bit;
  logic [HI_PAIR_W-1:0] hi_pair;
  logic [BYTE_W-1:0]    own_addr;

  i2c_am_bus_evt u_evt (
    .clk       (clk),
    .rst       (rst),
    .scl       (scl),
    .sda       (sda),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_am_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (reg_we),
    .sel      (reg_sel),
    .wdata    (reg_wdata),
    .gc_en    (gc_en),
    .ten_bit  (ten_bit),
    .hi_pair  (hi_pair),
    .own_addr (own_addr),
    .rdata    (reg_rdata)
  );

  i2c_am_fsm #(.BYTE_W(BYTE_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sda       (sda),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .gc_en     (gc_en),
    .ten_bit   (ten_bit),
    .hi_pair   (hi_pair),
    .own_addr  (own_addr),
    .addr_hit  (addr_hit),
    .gcall_hit (gcall_hit),
    .dir_tx    (dir_tx),
    .sda_pull  (sda_pull)
  );

endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_sel,
  input logic [2:0] rsv_bits,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       scl_fall,
  input logic       addr_hit,
  input logic       gcall_hit,
  input logic       dir_tx,
  input logic       sda_pull
);

  // R1: reserved control positions read back as zero
  p_rsv_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_sel) |-> (rsv_bits == 3'b000));

  // R2: STOP clears flags and releases SDA
  p_stop_clears_r2: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (!addr_hit && !gcall_hit && !sda_pull));

  // R2: START clears flags
  p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (!addr_hit && !gcall_hit && !dir_tx));

  // R4: acknowledge begins only after an SCL falling edge
  p_pull_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> $past(scl_fall));

  // R4: acknowledge ends on an SCL falling edge or a bus condition
  p_pull_release_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_pull) |-> ($past(scl_fall) || $past(start_evt) || $past(stop_evt)));

  // R6: general call reports write direction and no own-address match
  p_gc_write_r6: assert property (@(posedge clk) disable iff (rst)
    gcall_hit |-> (!dir_tx && !addr_hit));

endmodule

bind i2c_addr_match i2c_am_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_sel   (reg_sel),
  .rsv_bits  (reg_rdata[5:3]),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .scl_fall  (scl_fall),
  .addr_hit  (addr_hit),
  .gcall_hit (gcall_hit),
  .dir_tx    (dir_tx),
  .sda_pull  (sda_pull)
);

// File: tb/sim_i2c_addr_match.sv
`timescale 1ns/1ps
module sim_i2c_addr_match;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       reg_we = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  wire  [7:0] reg_rdata;
  wire        addr_hit, gcall_hit, dir_tx, sda_pull;
  wire        sda_line = sda_m & ~sda_pull;

  always #5 clk = ~clk;

  i2c_addr_match u0 (
    .clk       (clk),
    .rst       (rst),
    .scl       (scl),
    .sda       (sda_line),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .addr_hit  (addr_hit),
    .gcall_hit (gcall_hit),
    .dir_tx    (dir_tx),
    .sda_pull  (sda_pull)
  );

  int    checks = 0;
  int    errors = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";
  logic  e_hit = 1'b0, e_gc = 1'b0, e_dir = 1'b0, e_pull = 1'b0;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference model state compared on every clock
  always @(negedge clk) begin
    if (cmp_on && !done)
      check(cur_req, {4'b0, addr_hit, gcall_hit, dir_tx, sda_pull},
            {4'b0, e_hit, e_gc, e_dir, e_pull}, "hit/gc/dir/pull");
  end

  task automatic clear_exp();
    e_hit = 1'b0; e_gc = 1'b0; e_dir = 1'b0; e_pull = 1'b0;
  endtask

  task automatic reg_write(bit sel, logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic reg_read_check(bit sel, logic [7:0] exp, string req);
    reg_sel = sel;
    tick();
    check(req, reg_rdata, exp, "register readback");
  endtask

  task automatic bus_start();
    sda_m = 1'b1; idle(2);
    scl = 1'b1; idle(2);
    sda_m = 1'b0; tick();
    clear_exp();
    idle(2);
    scl = 1'b0; idle(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; idle(2);
    scl = 1'b1; idle(2);
    sda_m = 1'b1; tick();
    clear_exp();
    idle(3);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; idle(2);
      scl = 1'b1; idle(3);
      scl = 1'b0; idle(2);
    end
  endtask

  task automatic send_byte(logic [7:0] b, bit ack, bit hit, bit gc, bit dir);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; idle(2);
      scl = 1'b1; tick();
      if (i == 0) begin e_hit = hit; e_gc = gc; e_dir = dir; end
      idle(2);
      scl = 1'b0; tick();
      if (i == 0) e_pull = ack;
      idle(1);
    end
    sda_m = 1'b1; idle(2);
    scl = 1'b1; idle(3);
    scl = 1'b0; tick();
    e_pull = 1'b0;
    idle(2);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    tick();
    check("R1", {4'b0, addr_hit, gcall_hit, dir_tx, sda_pull}, 8'h00, "reset outputs");
    reg_read_check(1'b0, 8'h00, "R1");
    reg_read_check(1'b1, 8'h00, "R1");
    cmp_on = 1'b1;

    // R1 register fields
    reg_write(1'b1, 8'h5A); reg_read_check(1'b1, 8'h5A, "R1");
    reg_write(1'b0, 8'hFF); reg_read_check(1'b0, 8'hC7, "R1");
    reg_write(1'b0, 8'h00); reg_read_check(1'b0, 8'h00, "R1");

    // R3 / R4 seven-bit write and read
    cur_req = "R3"; bus_start(); send_byte(8'hB4, 1, 1, 0, 0);
    cur_req = "R2"; bus_stop();
    cur_req = "R4"; bus_start(); send_byte(8'hB5, 1, 1, 0, 1);
    cur_req = "R2"; bus_start();
    cur_req = "R3"; send_byte(8'hB4, 1, 1, 0, 0);
    cur_req = "R2"; bus_stop();

    // R5 mismatch then ignored byte
    cur_req = "R5"; bus_start(); send_byte(8'hB6, 0, 0, 0, 0);
    send_byte(8'hB4, 0, 0, 0, 0); bus_stop();

    // R2 STOP in the middle of a byte clears the shift state
    cur_req = "R2"; bus_start(); send_bits(8'hB4, 4); bus_stop();
    bus_start(); send_byte(8'hB4, 1, 1, 0, 0); bus_stop();

    // R6 general call
    cur_req = "R6"; bus_start(); send_byte(8'h00, 0, 0, 0, 0); bus_stop();
    reg_write(1'b0, 8'h80);
    bus_start(); send_byte(8'h00, 1, 0, 1, 0); bus_stop();
    bus_start(); send_byte(8'h01, 0, 0, 0, 0); bus_stop();

    // R7 address type latched at START
    cur_req = "R7"; reg_write(1'b0, 8'h00);
    bus_start(); reg_write(1'b0, 8'h40);
    send_byte(8'hB4, 1, 1, 0, 0); bus_stop();
    bus_start(); send_byte(8'hB4, 0, 0, 0, 0); bus_stop();

    // R8 ten-bit write, then R10 repeated-start read
    cur_req = "R8"; reg_write(1'b0, 8'h42);
    bus_start(); send_byte(8'hF4, 1, 0, 0, 0); send_byte(8'h5A, 1, 1, 0, 0);
    cur_req = "R10"; bus_start(); send_byte(8'hF5, 1, 1, 0, 1); bus_stop();
    cur_req = "R8"; bus_start(); send_byte(8'hF2, 0, 0, 0, 0); bus_stop();
    reg_write(1'b0, 8'h46);
    bus_start(); send_byte(8'hF4, 1, 0, 0, 0); send_byte(8'h5A, 1, 1, 0, 0); bus_stop();

    // R9 second byte mismatch, then read prefix is refused
    cur_req = "R9"; bus_start(); send_byte(8'hF4, 1, 0, 0, 0); send_byte(8'h5B, 0, 0, 0, 0);
    cur_req = "R10"; bus_start(); send_byte(8'hF5, 0, 0, 0, 0); bus_stop();
    bus_start(); send_byte(8'hF5, 0, 0, 0, 0); bus_stop();

    idle(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule